// File: doc/BRIEF.md
# March Test Engine for Single-Port SRAM

This block is a self-test engine placed in front of one single-port synchronous SRAM. While the test-mode input is low, the memory port passes the system-side address, write data and write enable straight through. While it is high, the engine owns the port. A start pulse launches one of three march tests. Each test is a list of elements. An element visits every address in ascending or descending order and applies a short, fixed list of write and read-and-compare operations to each address before it moves to the next one.

Operations are issued one per clock cycle. Each read is compared against its expected word in the following cycle, which matches a memory that registers its read data. The first mismatch sets a sticky fail flag and records the failing address and the word that was read. The test always runs to its last operation. The engine then raises done for a single cycle and keeps the verdict until the next start or reset.

Top module: `march_bist`

## Requirements
- R1: With testMode low, memAddr, memWdata and memWe equal sysAddr, sysWdata and sysWe. With testMode high, the engine drives them, and memWe stays low whenever the engine is idle.
- R2: algoSel selects the test: 0 is MATS+ `up{w0} up{r0,w1} down{r1,w0}` (5n operations); 1 is March X `up{w0} up{r0,w1} down{r1,w0} up{r0}` (6n); 2 and 3 are March C- `up{w0} up{r0,w1} up{r1,w0} down{r0,w1} down{r1,w0} up{r0}` (10n). n = 2^ADDR_W. A read cycle shows memWe low.
- R3: Each element applies all of its operations to one address before it moves on. Ascending elements run from 0 to n-1 and descending elements from n-1 to 0. Elements marked any-order run ascending.
- R4: A write of bit value v drives memWdata to v replicated across all DATA_W bits.
- R5: A read of value v compares memRdata, one cycle after the read is issued, against v replicated across all bits.
- R6: The first mismatch sets fail and captures failAddr and failData (the word read). Later mismatches in the same run change none of them.
- R7: The run never stops early. done is high for exactly one cycle. That cycle begins at the (N+1)-th rising edge after the edge that accepts start, where N is the operation count of R2.
- R8: start is ignored while a run is in progress. The run length and the operation order stay unchanged.
- R9: An accepted start clears fail, failAddr and failData to zero.
- R10: Active-low reset returns the engine to idle with done, fail, failAddr and failData all zero. A run cut short by reset issues no further operations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| testMode | input | 1 | High: the engine owns the memory port |
| start | input | 1 | Launches a test when the engine is idle |
| algoSel | input | 2 | Test selection (see R2) |
| sysAddr | input | ADDR_W | System-side address |
| sysWdata | input | DATA_W | System-side write data |
| sysWe | input | 1 | System-side write enable |
| memRdata | input | DATA_W | Read data from the SRAM, one cycle after its address |
| memAddr | output | ADDR_W | SRAM address |
| memWdata | output | DATA_W | SRAM write data |
| memWe | output | 1 | SRAM write enable |
| done | output | 1 | One-cycle end-of-test pulse |
| fail | output | 1 | Sticky mismatch flag |
| failAddr | output | ADDR_W | Address of the first mismatch |
| failData | output | DATA_W | Word read at the first mismatch |

## Verification
The port multiplexer is combinational, so its checks sample in the same cycle the system inputs are driven. Operation k of a run appears on the memory port in the cycle that starts k edges after the accepting edge. The bench builds its own operation trace from the algorithm lists and compares it against the port in the middle of every one of those cycles. The fail verdict settles one edge after the last read. done rises N+1 edges after acceptance, so the bench counts edges from the accepting edge, expects done exactly there, and reads fail, failAddr and failData in that same cycle. The bench then confirms that done is low one cycle later.

// File: rtl/march_bist_pkg.sv
`timescale 1ns/1ps
package march_bist_pkg;

  localparam logic [1:0] ALG_MATSP  = 2'd0;
  localparam logic [1:0] ALG_MARCHX = 2'd1;
  localparam logic [1:0] ALG_MARCHC = 2'd2;

  typedef struct packed {
    logic isWrite;
    logic val;
  } opT;

  typedef struct packed {
    logic       down;
    logic [1:0] nOps;
    opT         op0;
    opT         op1;
  } elemT;

  typedef struct packed {
    logic clear;
    logic addrLoad;
    logic loadDown;
    logic addrStep;
    logic stepDown;
    logic issue;
    logic isWrite;
    logic val;
  } strobeT;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2,
    ST_DONE  = 2'd3
  } stateT;

  localparam opT OP_W0 = '{isWrite: 1'b1, val: 1'b0};
  localparam opT OP_W1 = '{isWrite: 1'b1, val: 1'b1};
  localparam opT OP_R0 = '{isWrite: 1'b0, val: 1'b0};
  localparam opT OP_R1 = '{isWrite: 1'b0, val: 1'b1};

  function automatic elemT mkElem(input logic down, input logic [1:0] n,
                                  input opT a, input opT b);
    elemT e;
    e.down = down;
    e.nOps = n;
    e.op0  = a;
    e.op1  = b;
    return e;
  endfunction

  // Number of elements in each algorithm.
  function automatic logic [2:0] elemCount(input logic [1:0] alg);
    case (alg)
      ALG_MATSP:  return 3'd3;
      ALG_MARCHX: return 3'd4;
      default:    return 3'd6;
    endcase
  endfunction

  // Element descriptor; any-order elements are run ascending.
  function automatic elemT elemOf(input logic [1:0] alg, input logic [2:0] idx);
    elemT e;
    e = mkElem(1'b0, 2'd1, OP_W0, OP_W0);
    case (alg)
      ALG_MATSP: begin
        case (idx)
          3'd1:    e = mkElem(1'b0, 2'd2, OP_R0, OP_W1);
          3'd2:    e = mkElem(1'b1, 2'd2, OP_R1, OP_W0);
          default: e = mkElem(1'b0, 2'd1, OP_W0, OP_W0);
        endcase
      end
      ALG_MARCHX: begin
        case (idx)
          3'd1:    e = mkElem(1'b0, 2'd2, OP_R0, OP_W1);
          3'd2:    e = mkElem(1'b1, 2'd2, OP_R1, OP_W0);
          3'd3:    e = mkElem(1'b0, 2'd1, OP_R0, OP_R0);
          default: e = mkElem(1'b0, 2'd1, OP_W0, OP_W0);
        endcase
      end
      default: begin
        case (idx)
          3'd1:    e = mkElem(1'b0, 2'd2, OP_R0, OP_W1);
          3'd2:    e = mkElem(1'b0, 2'd2, OP_R1, OP_W0);
          3'd3:    e = mkElem(1'b1, 2'd2, OP_R0, OP_W1);
          3'd4:    e = mkElem(1'b1, 2'd2, OP_R1, OP_W0);
          3'd5:    e = mkElem(1'b0, 2'd1, OP_R0, OP_R0);
          default: e = mkElem(1'b0, 2'd1, OP_W0, OP_W0);
        endcase
      end
    endcase
    return e;
  endfunction

endpackage

// File: rtl/march_ctrl.sv
`timescale 1ns/1ps
module march_ctrl
  import march_bist_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [1:0] algoSel,
  input  logic       addrLast,
  output strobeT     stb,
  output logic       done
);

  stateT      state;
  logic [1:0] alg;
  logic [2:0] elemIdx;
  logic       opIdx;

  elemT cur;
  elemT nxt;
  elemT first;
  opT   curOp;
  logic lastOp;
  logic lastElem;

  always_comb begin
    cur      = elemOf(alg, elemIdx);
    nxt      = elemOf(alg, elemIdx + 3'd1);
    first    = elemOf(algoSel, 3'd0);
    curOp    = opIdx ? cur.op1 : cur.op0;
    lastOp   = ({1'b0, opIdx} == (cur.nOps - 2'd1));
    lastElem = (elemIdx == (elemCount(alg) - 3'd1));
  end

  always_comb begin
    stb = '0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          stb.clear    = 1'b1;
          stb.addrLoad = 1'b1;
          stb.loadDown = first.down;
        end
      end
      ST_RUN: begin
        stb.issue   = 1'b1;
        stb.isWrite = curOp.isWrite;
        stb.val     = curOp.val;
        if (lastOp) begin
          if (addrLast) begin
            if (!lastElem) begin
              stb.addrLoad = 1'b1;
              stb.loadDown = nxt.down;
            end
          end else begin
            stb.addrStep = 1'b1;
            stb.stepDown = cur.down;
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      alg     <= ALG_MATSP;
      elemIdx <= 3'd0;
      opIdx   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            alg     <= algoSel;
            elemIdx <= 3'd0;
            opIdx   <= 1'b0;
            state   <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (lastOp) begin
            opIdx <= 1'b0;
            if (addrLast) begin
              if (lastElem) state <= ST_DRAIN;
              else          elemIdx <= elemIdx + 3'd1;
            end
          end else begin
            opIdx <= 1'b1;
          end
        end
        ST_DRAIN: state <= ST_DONE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assign done = (state == ST_DONE);

  AST_OP_IN_ELEM: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN) |-> ({1'b0, opIdx} < cur.nOps)); // R3
  AST_ELEM_MONOTONIC: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && $past(state) == ST_RUN) |-> (elemIdx >= $past(elemIdx))); // R8
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R7
  AST_DONE_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> ($past(state) == ST_DRAIN)); // R7

endmodule

// File: rtl/march_dp.sv
`timescale 1ns/1ps
module march_dp
  import march_bist_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            stb,
  input  logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] bistAddr,
  output logic [DATA_W-1:0] bistWdata,
  output logic              bistWe,
  output logic              addrLast,
  output logic              fail,
  output logic [ADDR_W-1:0] failAddr,
  output logic [DATA_W-1:0] failData
);

  localparam logic [ADDR_W-1:0] ADDR_TOP = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] ADDR_ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  logic [ADDR_W-1:0] addr;
  logic              dirDown;
  logic              cmpValid;
  logic [DATA_W-1:0] cmpExp;
  logic [ADDR_W-1:0] cmpAddr;
  logic              mismatch;

  // Address counter; dirDown tracks the current element's direction.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addr    <= '0;
      dirDown <= 1'b0;
    end else if (stb.addrLoad) begin
      addr    <= stb.loadDown ? ADDR_TOP : '0;
      dirDown <= stb.loadDown;
    end else if (stb.addrStep) begin
      addr    <= stb.stepDown ? (addr - ADDR_ONE) : (addr + ADDR_ONE);
    end
  end

  assign addrLast  = dirDown ? (addr == '0) : (addr == ADDR_TOP);
  assign bistAddr  = addr;
  assign bistWe    = stb.issue & stb.isWrite;
  assign bistWdata = {DATA_W{stb.val}};

  // Read pipeline: expected word and address follow the read by one cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmpValid <= 1'b0;
      cmpExp   <= '0;
      cmpAddr  <= '0;
    end else begin
      cmpValid <= stb.issue & ~stb.isWrite;
      cmpExp   <= {DATA_W{stb.val}};
      cmpAddr  <= addr;
    end
  end

  assign mismatch = cmpValid && (rdData != cmpExp);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fail     <= 1'b0;
      failAddr <= '0;
      failData <= '0;
    end else if (stb.clear) begin
      fail     <= 1'b0;
      failAddr <= '0;
      failData <= '0;
    end else if (mismatch && !fail) begin
      fail     <= 1'b1;
      failAddr <= cmpAddr;
      failData <= rdData;
    end
  end

  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (fail && !stb.clear) |=> fail); // R6
  AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (fail && $past(fail) && !$past(stb.clear)) |-> ($stable(failAddr) && $stable(failData))); // R6
  AST_CLEAR_ON_START: assert property (@(posedge clk) disable iff (!rstN)
    stb.clear |=> (!fail && failAddr == '0)); // R9

endmodule

// File: rtl/march_bist.sv
`timescale 1ns/1ps
module march_bist
  import march_bist_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              testMode,
  input  logic              start,
  input  logic [1:0]        algoSel,
  input  logic [ADDR_W-1:0] sysAddr,
  input  logic [DATA_W-1:0] sysWdata,
  input  logic              sysWe,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              memWe,
  output logic              done,
  output logic              fail,
  output logic [ADDR_W-1:0] failAddr,
  output logic [DATA_W-1:0] failData
);

  strobeT            stb;
  logic              addrLast;
  logic [ADDR_W-1:0] bistAddr;
  logic [DATA_W-1:0] bistWdata;
  logic              bistWe;

  march_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .algoSel  (algoSel),
    .addrLast (addrLast),
    .stb      (stb),
    .done     (done)
  );

  march_dp #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .rdData    (memRdata),
    .bistAddr  (bistAddr),
    .bistWdata (bistWdata),
    .bistWe    (bistWe),
    .addrLast  (addrLast),
    .fail      (fail),
    .failAddr  (failAddr),
    .failData  (failData)
  );

  always_comb begin
    if (testMode) begin
      memAddr  = bistAddr;
      memWdata = bistWdata;
      memWe    = bistWe;
    end else begin
      memAddr  = sysAddr;
      memWdata = sysWdata;
      memWe    = sysWe;
    end
  end

  AST_TEST_WE_ONLY_RUN: assert property (@(posedge clk) disable iff (!rstN)
    (testMode && memWe) |-> stb.issue); // R1

endmodule

// File: tb/sim_march_bist.sv
`timescale 1ns/1ps
module sim_march_bist;

  localparam int AW = 6;
  localparam int DW = 8;
  localparam int NW = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          testMode = 1'b0;
  logic          start = 1'b0;
  logic [1:0]    algoSel = 2'd0;
  logic [AW-1:0] sysAddr = '0;
  logic [DW-1:0] sysWdata = '0;
  logic          sysWe = 1'b0;
  logic [DW-1:0] memRdata;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memWdata;
  logic          memWe;
  logic          done;
  logic          fail;
  logic [AW-1:0] failAddr;
  logic [DW-1:0] failData;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  march_bist #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rstN(rstN), .testMode(testMode), .start(start), .algoSel(algoSel),
    .sysAddr(sysAddr), .sysWdata(sysWdata), .sysWe(sysWe), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata), .memWe(memWe), .done(done),
    .fail(fail), .failAddr(failAddr), .failData(failData)
  );

  // SRAM model with injectable stuck-at and falling-transition faults.
  logic [DW-1:0] mem [NW];
  logic          memClr = 1'b0;
  logic          saEn [2];
  logic [AW-1:0] saAddr [2];
  logic [2:0]    saBit [2];
  logic          saVal [2];
  logic          tfEn = 1'b0;
  logic [AW-1:0] tfAddr = '0;
  logic [2:0]    tfBit = '0;

  function automatic logic [DW-1:0] faulty(input logic [AW-1:0] a, input logic [DW-1:0] d);
    logic [DW-1:0] r;
    r = d;
    for (int s = 0; s < 2; s++)
      if (saEn[s] && a == saAddr[s]) r[saBit[s]] = saVal[s];
    return r;
  endfunction

  always @(posedge clk) begin
    logic [DW-1:0] nv;
    if (memClr) begin
      for (int i = 0; i < NW; i++) mem[i] <= '0;
    end else if (memWe) begin
      nv = memWdata;
      if (tfEn && memAddr == tfAddr && mem[memAddr][tfBit] && !nv[tfBit]) nv[tfBit] = 1'b1;
      mem[memAddr] <= nv;
    end
    memRdata <= faulty(memAddr, mem[memAddr]);
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Bench-side algorithm table: {down, nOps[1:0], w0, v0, w1, v1}
  function automatic logic [6:0] bElem(input int alg, input int e);
    case (alg)
      0: case (e)
           0: return 7'b0_01_10_00;
           1: return 7'b0_10_00_11;
           2: return 7'b1_10_01_10;
           default: return '0;
         endcase
      1: case (e)
           0: return 7'b0_01_10_00;
           1: return 7'b0_10_00_11;
           2: return 7'b1_10_01_10;
           3: return 7'b0_01_00_00;
           default: return '0;
         endcase
      default: case (e)
           0: return 7'b0_01_10_00;
           1: return 7'b0_10_00_11;
           2: return 7'b0_10_01_10;
           3: return 7'b1_10_00_11;
           4: return 7'b1_10_01_10;
           5: return 7'b0_01_00_00;
           default: return '0;
         endcase
    endcase
  endfunction

  logic [AW-1:0] eAddr [1024];
  logic          eWe [1024];
  logic          eVal [1024];

  function automatic int buildTrace(input int alg);
    int n = 0;
    for (int e = 0; e < 6; e++) begin
      logic [6:0] d;
      d = bElem(alg, e);
      if (d[5:4] == 2'd0) break;
      for (int k = 0; k < NW; k++) begin
        for (int o = 0; o < int'(d[5:4]); o++) begin
          eAddr[n] = d[6] ? AW'(NW - 1 - k) : AW'(k);
          eWe[n]   = (o == 0) ? d[3] : d[1];
          eVal[n]  = (o == 0) ? d[2] : d[0];
          n++;
        end
      end
    end
    return n;
  endfunction

  task automatic clearFaults();
    for (int s = 0; s < 2; s++) begin
      saEn[s] = 1'b0; saAddr[s] = '0; saBit[s] = '0; saVal[s] = 1'b0;
    end
    tfEn = 1'b0;
  endtask

  task automatic zeroMem();
    @(negedge clk); memClr = 1'b1;
    @(negedge clk); memClr = 1'b0;
  endtask

  // Runs one test; checks trace (R2,R3,R4), timing (R7), start-ignore (R8) and verdict (R5,R6,R9).
  task automatic runAlgo(input int alg, input bit poke, input bit expFail,
                         input logic [AW-1:0] expAddr, input logic [DW-1:0] expData,
                         input string tag);
    int n;
    int idx;
    int bad;
    int firstBad;
    n = buildTrace(alg);
    zeroMem();
    testMode = 1'b1;
    algoSel = 2'(alg);
    start = 1'b1;
    @(posedge clk);
    idx = 0; bad = 0; firstBad = -1;
    forever begin
      @(negedge clk);
      start = (poke && idx == 40) ? 1'b1 : 1'b0;
      if (idx == 41 && poke) algoSel = 2'd0;
      if (idx < n) begin
        if (memAddr !== eAddr[idx] || memWe !== eWe[idx] ||
            (eWe[idx] && memWdata !== {DW{eVal[idx]}})) begin
          bad++;
          if (firstBad < 0) firstBad = idx;
        end
      end
      if (done === 1'b1 || idx > n + 10) break;
      idx++;
    end
    start = 1'b0;
    chk(bad == 0, {"R2 R3 R4 trace ", tag}, 32'(firstBad), 32'(-1));
    chk(idx == n + 1, {"R7 done timing ", tag}, 32'(idx), 32'(n + 1));
    chk(fail === expFail, {"R5 R6 fail flag ", tag}, 32'(fail), 32'(expFail));
    chk(failAddr === expAddr && failData === expData, {"R6 R9 capture ", tag},
        {16'(failAddr), 16'(failData)}, {16'(expAddr), 16'(expData)});
    @(negedge clk);
    chk(done === 1'b0, {"R7 done single cycle ", tag}, 32'(done), 32'd0);
    algoSel = 2'd0;
  endtask

  task automatic testReset();
    @(negedge clk);
    chk(done === 1'b0 && fail === 1'b0 && failAddr === '0 && failData === '0,
        "R10 reset state", {30'(0), done, fail}, 32'd0);
    testMode = 1'b1;
    @(negedge clk);
    chk(memWe === 1'b0, "R1 idle engine keeps write low", 32'(memWe), 32'd0);
  endtask

  task automatic testMux();
    testMode = 1'b0;
    sysAddr = 6'h2a; sysWdata = 8'h5c; sysWe = 1'b1;
    @(negedge clk);
    chk(memAddr === 6'h2a && memWdata === 8'h5c && memWe === 1'b1, "R1 system pass-through",
        {15'(0), memWe, 8'(memAddr), memWdata}, {15'(0), 1'b1, 8'h2a, 8'h5c});
    sysAddr = 6'h13; sysWdata = 8'hc3; sysWe = 1'b0;
    @(negedge clk);
    chk(memAddr === 6'h13 && memWdata === 8'hc3 && memWe === 1'b0, "R1 system pass-through read",
        {15'(0), memWe, 8'(memAddr), memWdata}, {15'(0), 1'b0, 8'h13, 8'hc3});
    testMode = 1'b1;
  endtask

  task automatic testMidReset();
    zeroMem();
    algoSel = 2'd2;
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (30) @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    chk(done === 1'b0 && fail === 1'b0 && failAddr === '0 && failData === '0,
        "R10 reset mid-run clears flags", {30'(0), done, fail}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk(memWe === 1'b0, "R10 no operations after reset", 32'(memWe), 32'd0);
  endtask

  initial begin
    clearFaults();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testMux();
    // Clean runs of every algorithm.
    runAlgo(0, 1'b0, 1'b0, '0, '0, "matsp clean");
    runAlgo(1, 1'b0, 1'b0, '0, '0, "marchx clean");
    runAlgo(2, 1'b0, 1'b0, '0, '0, "marchc clean");
    runAlgo(3, 1'b0, 1'b0, '0, '0, "sel3 clean");
    // Stuck-at-1 read during ascending r0 (R5).
    saEn[0] = 1'b1; saAddr[0] = 6'd9; saBit[0] = 3'd2; saVal[0] = 1'b1;
    runAlgo(0, 1'b0, 1'b1, 6'd9, 8'h04, "matsp sa1");
    // Two stuck-at-0 cells, first seen in descending element: the higher one (R3, R6).
    clearFaults();
    saEn[0] = 1'b1; saAddr[0] = 6'd5;  saBit[0] = 3'd0; saVal[0] = 1'b0;
    saEn[1] = 1'b1; saAddr[1] = 6'd40; saBit[1] = 3'd7; saVal[1] = 1'b0;
    runAlgo(0, 1'b0, 1'b1, 6'd40, 8'h7f, "matsp two sa0");
    // Two stuck-at-1 cells under March C-: first capture kept (R6), start poke ignored (R8).
    clearFaults();
    saEn[0] = 1'b1; saAddr[0] = 6'd10; saBit[0] = 3'd3; saVal[0] = 1'b1;
    saEn[1] = 1'b1; saAddr[1] = 6'd63; saBit[1] = 3'd6; saVal[1] = 1'b1;
    runAlgo(2, 1'b1, 1'b1, 6'd10, 8'h08, "marchc sticky");
    // Falling-transition fault: missed by MATS+, caught by the final r0 of March X (R2).
    clearFaults();
    tfEn = 1'b1; tfAddr = 6'd0; tfBit = 3'd5;
    runAlgo(0, 1'b0, 1'b0, '0, '0, "matsp tf miss");
    runAlgo(1, 1'b0, 1'b1, 6'd0, 8'h20, "marchx tf");
    // Next start clears previous verdict (R9).
    clearFaults();
    runAlgo(1, 1'b1, 1'b0, '0, '0, "marchx after fail");
    testMidReset();
    runAlgo(2, 1'b0, 1'b0, '0, '0, "marchc after reset");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule